// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block sits on the host side of a single-line SPI flash. A client hands it one request at a time through a ready/valid handshake. A request carries a kind code, a 24-bit address, a byte count and a wrap-size code. The sequencer turns the request into one or more chip-select frames. It drives chip select, the serial clock and the data-out line in SPI mode 0, and it samples the data-in line. Read bytes come back on a strobed byte output. Program bytes are pulled from the client one at a time through a pop strobe.

Some requests need more than one frame. Any program or erase is preceded by its own write-enable frame. After a program or erase, the sequencer keeps issuing status reads until the busy bit clears, and only then reports completion. A device reset is sent as two separate frames. A program whose data would run past the end of its 256-byte page is refused before any bus activity. The serial clock runs at a fixed division of the system clock. The division and the minimum deselect time between frames are parameters.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is low and `req_ready` is high. The serial clock stays low whenever chip select is high.
- R2: Every frame uses SPI mode 0. Bytes go out most-significant bit first, and data-out never changes while the serial clock is high or on its rising edge. Addresses go out as three bytes, high byte first.
- R3: Kind 0 (read) sends 03h and the address, then clocks `req_len` bytes in. Each byte is presented in order on `rd_data` with a one-cycle `rd_valid`.
- R4: Kind 1 (fast read) sends 0Bh, the address and then eight dummy clocks (one 00h byte), before it clocks `req_len` data bytes in.
- R5: Kinds 2 to 6 and kind 11 start with a frame of their own: a single 06h byte for kinds 2 to 6, and a single 66h byte for kind 11. Between any two frames, chip select stays high for at least CS_HIGH system clock cycles.
- R6: Kind 2 (page program) sends 02h, the address and `req_len` bytes taken from `wr_data`, one per `wr_ready` strobe. A request of kind 0, 1 or 2 with `req_len` of 0 is refused with a one-cycle `err` and no frame. A program request where address[7:0] + `req_len` exceeds 256 is refused the same way. Exactly 256 is accepted.
- R7: Kind 3 sends 20h, kind 4 sends 52h and kind 5 sends D8h, each followed by the address. Kind 6 (whole chip) sends a single byte: C7h when CHIP_ERASE_ALT is 0, or 60h when it is 1.
- R8: After the main frame of kinds 2 to 6, the block repeats a two-byte frame of 05h plus one read byte. It stops once bit 0 of the read byte is 0, and only then pulses `done`. Poll bytes do not appear on `rd_data`.
- R9: Kind 7 sends 05h and returns one status byte on `rd_data`. Kind 8 sends 9Fh and returns three identification bytes.
- R10: Kind 9 sends B9h alone, kind 10 sends ABh alone and kind 13 sends 04h alone. Each is a one-byte frame.
- R11: Kind 11 sends 66h in one frame, then 99h in a second frame.
- R12: Kind 12 sends 77h, three 00h bytes and then a wrap byte. In the wrap byte, bits 6:5 equal `req_wrap` (0 = 8 bytes, 1 = 16, 2 = 32, 3 = 64) and all other bits are 0.
- R13: `req_ready` is low from the cycle after a request is accepted until the request ends. Each accepted request ends with exactly one one-cycle pulse of either `done` or `err`, and `req_ready` rises in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_kind | input | 4 | Request kind code (0 to 13) |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Data byte count for read, fast read and program |
| req_wrap | input | 2 | Wrap size code for kind 12 |
| wr_data | input | 8 | Next program byte, valid while wr_ready is high |
| wr_ready | output | 1 | Pop strobe: wr_data is taken this cycle |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | rd_data holds a new byte |
| done | output | 1 | Request completed |
| err | output | 1 | Request refused by the length check |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with DIV_HALF = 2, CS_HIGH = 3, LEN_W = 9 and CHIP_ERASE_ALT = 0. The short clock half-period keeps a full 256-byte program cheap enough to run, so the page-length check can be tested on both sides of the limit. A 9-bit length field can also express a count that crosses the page end. A three-cycle deselect gap is long enough to measure from the bench's flash model, and the default chip-erase variant is the one whose opcode is checked.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

   localparam int ADDR_W     = 24;
   localparam int PAGE_BYTES = 256;

   typedef enum logic [3:0] {
      K_READ    = 4'd0,
      K_FAST    = 4'd1,
      K_PROG    = 4'd2,
      K_ER4K    = 4'd3,
      K_ER32K   = 4'd4,
      K_ER64K   = 4'd5,
      K_ERCHIP  = 4'd6,
      K_STATUS  = 4'd7,
      K_IDENT   = 4'd8,
      K_SLEEP   = 4'd9,
      K_WAKE    = 4'd10,
      K_RESET   = 4'd11,
      K_WRAP    = 4'd12,
      K_WR_DIS  = 4'd13
   } nor_kind_e;

   typedef enum logic [1:0] {
      PH_PRE,
      PH_MAIN,
      PH_POLL
   } nor_phase_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CHK,
      S_GAP,
      S_LOAD,
      S_WAIT,
      S_END
   } nor_state_e;

   localparam logic [7:0] OP_WR_EN    = 8'h06;
   localparam logic [7:0] OP_WR_DIS   = 8'h04;
   localparam logic [7:0] OP_STAT     = 8'h05;
   localparam logic [7:0] OP_RD       = 8'h03;
   localparam logic [7:0] OP_RD_FAST  = 8'h0B;
   localparam logic [7:0] OP_PROG     = 8'h02;
   localparam logic [7:0] OP_ER4K     = 8'h20;
   localparam logic [7:0] OP_ER32K    = 8'h52;
   localparam logic [7:0] OP_ER64K    = 8'hD8;
   localparam logic [7:0] OP_ERCHIP_A = 8'h60;
   localparam logic [7:0] OP_ERCHIP_B = 8'hC7;
   localparam logic [7:0] OP_SLEEP    = 8'hB9;
   localparam logic [7:0] OP_WAKE     = 8'hAB;
   localparam logic [7:0] OP_IDENT    = 8'h9F;
   localparam logic [7:0] OP_RST_ARM  = 8'h66;
   localparam logic [7:0] OP_RST_GO   = 8'h99;
   localparam logic [7:0] OP_WRAP_SET = 8'h77;

   function automatic logic kind_alters_array(nor_kind_e k);
      return (k == K_PROG) || (k == K_ER4K) || (k == K_ER32K) ||
             (k == K_ER64K) || (k == K_ERCHIP);
   endfunction

   function automatic logic kind_has_len(nor_kind_e k);
      return (k == K_READ) || (k == K_FAST) || (k == K_PROG);
   endfunction

endpackage

// File: rtl/nor_bit_engine.sv
module nor_bit_engine #(
   parameter int DIV_HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx_byte
);

   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

   logic          active;
   logic [CW-1:0] cnt;
   logic [2:0]    bitn;
   logic [7:0]    sreg;
   logic          tick;

   assign tick = active && (cnt == CW'(DIV_HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         cnt     <= '0;
         bitn    <= '0;
         sreg    <= '0;
         sclk    <= 1'b0;
         mosi    <= 1'b0;
         done    <= 1'b0;
         rx_byte <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            bitn   <= '0;
            sreg   <= tx_byte;
            mosi   <= tx_byte[7];
            sclk   <= 1'b0;
         end else if (active) begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick) begin
               if (!sclk) begin
                  sclk    <= 1'b1;
                  rx_byte <= {rx_byte[6:0], miso};
               end else begin
                  sclk <= 1'b0;
                  if (bitn == 3'd7) begin
                     active <= 1'b0;
                     done   <= 1'b1;
                  end else begin
                     bitn <= bitn + 1'b1;
                     mosi <= sreg[6];
                     sreg <= {sreg[6:0], 1'b0};
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/nor_req_check.sv
module nor_req_check
   import nor_seq_pkg::*;
#(
   parameter int LEN_W = 9
) (
   input  nor_kind_e        kind,
   input  logic [7:0]       addr_lo,
   input  logic [LEN_W-1:0] len,
   output logic             bad
);

   logic [LEN_W:0] end_pos;
   logic           len_zero;
   logic           past_page;

   assign end_pos   = (LEN_W+1)'(addr_lo) + (LEN_W+1)'(len);
   assign len_zero  = (len == '0);
   assign past_page = end_pos > (LEN_W+1)'(PAGE_BYTES);

   always_comb begin
      bad = 1'b0;
      if (kind_has_len(kind) && len_zero)
         bad = 1'b1;
      if ((kind == K_PROG) && past_page)
         bad = 1'b1;
   end

endmodule

// File: rtl/nor_frame_plan.sv
module nor_frame_plan
   import nor_seq_pkg::*;
#(
   parameter int LEN_W          = 9,
   parameter bit CHIP_ERASE_ALT = 1'b0,
   localparam int IDX_W         = LEN_W + 1
) (
   input  nor_kind_e         kind,
   input  nor_phase_e        phase,
   input  logic [IDX_W-1:0]  idx,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   input  logic [1:0]        wrap,
   input  logic [7:0]        wr_data,
   output logic [7:0]        tx_byte,
   output logic              last,
   output logic              rx_slot,
   output logic              wr_take,
   output logic              needs_pre,
   output logic              needs_poll
);

   logic [7:0]       chip_op;
   logic [7:0]       op;
   logic [2:0]       hdr;
   logic [LEN_W-1:0] dlen;
   logic             rx_kind;
   logic             in_data;
   logic [IDX_W-1:0] total;

   generate
      if (CHIP_ERASE_ALT) begin : g_chip_a
         assign chip_op = OP_ERCHIP_A;
      end else begin : g_chip_b
         assign chip_op = OP_ERCHIP_B;
      end
   endgenerate

   assign needs_pre  = kind_alters_array(kind) || (kind == K_RESET);
   assign needs_poll = kind_alters_array(kind);

   always_comb begin
      op      = OP_WR_EN;
      hdr     = 3'd1;
      dlen    = '0;
      rx_kind = 1'b0;
      case (phase)
         PH_PRE:  op = (kind == K_RESET) ? OP_RST_ARM : OP_WR_EN;
         PH_POLL: begin
            op      = OP_STAT;
            dlen    = LEN_W'(1);
            rx_kind = 1'b1;
         end
         default: begin
            case (kind)
               K_READ:   begin op = OP_RD;      hdr = 3'd4; dlen = len; rx_kind = 1'b1; end
               K_FAST:   begin op = OP_RD_FAST; hdr = 3'd5; dlen = len; rx_kind = 1'b1; end
               K_PROG:   begin op = OP_PROG;    hdr = 3'd4; dlen = len; end
               K_ER4K:   begin op = OP_ER4K;    hdr = 3'd4; end
               K_ER32K:  begin op = OP_ER32K;   hdr = 3'd4; end
               K_ER64K:  begin op = OP_ER64K;   hdr = 3'd4; end
               K_ERCHIP: op = chip_op;
               K_STATUS: begin op = OP_STAT;  dlen = LEN_W'(1); rx_kind = 1'b1; end
               K_IDENT:  begin op = OP_IDENT; dlen = LEN_W'(3); rx_kind = 1'b1; end
               K_SLEEP:  op = OP_SLEEP;
               K_WAKE:   op = OP_WAKE;
               K_RESET:  op = OP_RST_GO;
               K_WRAP:   begin op = OP_WRAP_SET; hdr = 3'd5; end
               default:  op = OP_WR_DIS;
            endcase
         end
      endcase
   end

   assign total   = IDX_W'(hdr) + IDX_W'(dlen);
   assign last    = (idx == total - 1'b1);
   assign in_data = (idx >= IDX_W'(hdr));
   assign rx_slot = in_data && rx_kind;
   assign wr_take = in_data && (phase == PH_MAIN) && (kind == K_PROG);

   always_comb begin
      tx_byte = 8'h00;
      if (idx == '0)
         tx_byte = op;
      else if (!in_data) begin
         if (kind != K_WRAP) begin
            case (idx[2:0])
               3'd1:    tx_byte = addr[23:16];
               3'd2:    tx_byte = addr[15:8];
               3'd3:    tx_byte = addr[7:0];
               default: tx_byte = 8'h00;
            endcase
         end else if (idx[2:0] == 3'd4)
            tx_byte = {1'b0, wrap, 5'b00000};
      end else if (wr_take)
         tx_byte = wr_data;
   end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_seq_pkg::*;
#(
   parameter int DIV_HALF       = 2,
   parameter int CS_HIGH        = 3,
   parameter int LEN_W          = 9,
   parameter bit CHIP_ERASE_ALT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [3:0]       req_kind,
   input  logic [23:0]      req_addr,
   input  logic [LEN_W-1:0] req_len,
   input  logic [1:0]       req_wrap,
   input  logic [7:0]       wr_data,
   output logic             wr_ready,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   output logic             done,
   output logic             err,
   output logic             spi_cs_n,
   output logic             spi_sclk,
   output logic             spi_mosi,
   input  logic             spi_miso
);

   localparam int IDX_W = LEN_W + 1;
   localparam int GW    = $clog2(CS_HIGH + 1);

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if ((CS_HIGH < 1) || (CS_HIGH > 200)) begin : g_bad_gap
         $error("CS_HIGH must lie in 1..200");
      end
      if (LEN_W < 9) begin : g_bad_len
         $error("LEN_W must hold a full page count");
      end
   endgenerate

   nor_state_e        state;
   nor_phase_e        phase;
   nor_kind_e         kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic [1:0]        wrap_q;
   logic [IDX_W-1:0]  idx;
   logic [GW-1:0]     gap;
   logic              stat_busy;

   logic              bad;
   logic [7:0]        tx_byte;
   logic              last;
   logic              rx_slot;
   logic              wr_take;
   logic              needs_pre;
   logic              needs_poll;
   logic              eng_start;
   logic              eng_done;
   logic [7:0]        eng_rx;

   assign req_ready = (state == S_IDLE);
   assign eng_start = (state == S_LOAD);
   assign wr_ready  = eng_start && wr_take;

   nor_req_check #(.LEN_W(LEN_W)) u_check (
      .kind    (kind_q),
      .addr_lo (addr_q[7:0]),
      .len     (len_q),
      .bad     (bad)
   );

   nor_frame_plan #(.LEN_W(LEN_W), .CHIP_ERASE_ALT(CHIP_ERASE_ALT)) u_plan (
      .kind       (kind_q),
      .phase      (phase),
      .idx        (idx),
      .addr       (addr_q),
      .len        (len_q),
      .wrap       (wrap_q),
      .wr_data    (wr_data),
      .tx_byte    (tx_byte),
      .last       (last),
      .rx_slot    (rx_slot),
      .wr_take    (wr_take),
      .needs_pre  (needs_pre),
      .needs_poll (needs_poll)
   );

   nor_bit_engine #(.DIV_HALF(DIV_HALF)) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (eng_start),
      .tx_byte (tx_byte),
      .miso    (spi_miso),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi),
      .done    (eng_done),
      .rx_byte (eng_rx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         phase     <= PH_MAIN;
         kind_q    <= K_READ;
         addr_q    <= '0;
         len_q     <= '0;
         wrap_q    <= '0;
         idx       <= '0;
         gap       <= '0;
         stat_busy <= 1'b0;
         spi_cs_n  <= 1'b1;
         rd_data   <= '0;
         rd_valid  <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
      end else begin
         done     <= 1'b0;
         err      <= 1'b0;
         rd_valid <= 1'b0;
         case (state)
            S_IDLE: begin
               if (req_valid) begin
                  kind_q <= nor_kind_e'(req_kind);
                  addr_q <= req_addr;
                  len_q  <= req_len;
                  wrap_q <= req_wrap;
                  state  <= S_CHK;
               end
            end
            S_CHK: begin
               if (bad) begin
                  err   <= 1'b1;
                  state <= S_IDLE;
               end else begin
                  phase <= needs_pre ? PH_PRE : PH_MAIN;
                  gap   <= '0;
                  state <= S_GAP;
               end
            end
            S_GAP: begin
               if (gap == GW'(CS_HIGH - 1)) begin
                  spi_cs_n <= 1'b0;
                  idx      <= '0;
                  state    <= S_LOAD;
               end else
                  gap <= gap + 1'b1;
            end
            S_LOAD: state <= S_WAIT;
            S_WAIT: begin
               if (eng_done) begin
                  if (rx_slot) begin
                     if (phase == PH_POLL)
                        stat_busy <= eng_rx[0];
                     else begin
                        rd_data  <= eng_rx;
                        rd_valid <= 1'b1;
                     end
                  end
                  if (last)
                     state <= S_END;
                  else begin
                     idx   <= idx + 1'b1;
                     state <= S_LOAD;
                  end
               end
            end
            default: begin
               spi_cs_n <= 1'b1;
               gap      <= '0;
               if (phase == PH_PRE) begin
                  phase <= PH_MAIN;
                  state <= S_GAP;
               end else if ((phase == PH_MAIN) && needs_poll) begin
                  phase <= PH_POLL;
                  state <= S_GAP;
               end else if ((phase == PH_POLL) && stat_busy)
                  state <= S_GAP;
               else begin
                  done  <= 1'b1;
                  state <= S_IDLE;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
   parameter int CS_HIGH = 3
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic wr_ready,
   input logic done,
   input logic err,
   input logic spi_cs_n,
   input logic spi_sclk,
   input logic spi_mosi
);

   logic [7:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_q <= '0;
      else if (!spi_cs_n)
         hi_q <= '0;
      else if (hi_q != 8'hFF)
         hi_q <= hi_q + 1'b1;
   end

   // R1
   idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   // R2
   mosi_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sclk) |-> $stable(spi_mosi));

   // R2
   mosi_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

   // R5
   cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (hi_q >= 8'(CS_HIGH)));

   // R6
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (spi_cs_n && !done));

   // R6
   pop_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> !spi_cs_n);

   // R13
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> !req_ready);

   // R13
   accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R13
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.CS_HIGH(CS_HIGH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .wr_ready  (wr_ready),
   .done      (done),
   .err       (err),
   .spi_cs_n  (spi_cs_n),
   .spi_sclk  (spi_sclk),
   .spi_mosi  (spi_mosi)
);

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/1ps
module sim_nor_cmd_seq;

   localparam int DIV_HALF   = 2;
   localparam int CS_HIGH    = 3;
   localparam int LEN_W      = 9;
   localparam int BUSY_POLLS = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [3:0]       req_kind = '0;
   logic [23:0]      req_addr = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic [1:0]       req_wrap = '0;
   logic [7:0]       wr_data = '0;
   logic             wr_ready;
   logic [7:0]       rd_data;
   logic             rd_valid;
   logic             done;
   logic             err;
   logic             spi_cs_n;
   logic             spi_sclk;
   logic             spi_mosi;
   logic             spi_miso = 1'b0;

   int checks = 0;
   int errors = 0;

   nor_cmd_seq #(.DIV_HALF(DIV_HALF), .CS_HIGH(CS_HIGH), .LEN_W(LEN_W),
                 .CHIP_ERASE_ALT(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len),
      .req_wrap(req_wrap), .wr_data(wr_data), .wr_ready(wr_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
      .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso)
   );

   always #2.5 clk = ~clk;

   // flash model state
   int         mbits;
   logic [7:0] cur;
   logic [7:0] fb [0:7];
   logic [7:0] dcap [0:259];
   logic [7:0] flog [0:15][0:7];
   int         flen [0:15];
   int         nf;
   int         busy_left = 0;
   real        tr = 0.0;
   real        gap_min;

   // client side state
   logic [7:0] rdb [0:15];
   int         rd_cnt, done_cnt, err_cnt;
   logic [7:0] pbuf [0:255];
   int         wr_idx;

   function automatic logic [7:0] memb(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   function automatic logic resp_bit();
      int k;
      int b;
      logic [7:0] r;
      logic [23:0] a;
      k = mbits / 8;
      b = 7 - (mbits % 8);
      a = {fb[1], fb[2], fb[3]};
      r = 8'h00;
      case (fb[0])
         8'h03: if (k >= 4) r = memb(a + 24'(k - 4));
         8'h0B: if (k >= 5) r = memb(a + 24'(k - 5));
         8'h05: if (k >= 1) r = {7'b0, (busy_left > 0)};
         8'h9F: if (k == 1) r = 8'hA1; else if (k == 2) r = 8'hB2;
                else if (k == 3) r = 8'hC3;
         default: r = 8'h00;
      endcase
      return r[b];
   endfunction

   initial forever begin
      @(negedge spi_cs_n);
      mbits = 0;
      for (int j = 0; j < 8; j++) fb[j] = 8'h00;
      if ((($realtime - tr) / 5.0) < gap_min) gap_min = ($realtime - tr) / 5.0;
   end

   initial forever begin
      @(posedge spi_sclk);
      if (!spi_cs_n) begin
         cur = {cur[6:0], spi_mosi};
         mbits++;
         if (mbits % 8 == 0) begin
            if (mbits / 8 - 1 < 8) fb[mbits / 8 - 1] = cur;
            if (fb[0] == 8'h02 && mbits / 8 - 1 >= 4 && mbits / 8 - 1 < 264)
               dcap[mbits / 8 - 5] = cur;
         end
      end
   end

   initial forever begin
      @(negedge spi_sclk);
      if (!spi_cs_n) spi_miso = resp_bit();
   end

   initial forever begin
      @(posedge spi_cs_n);
      tr = $realtime;
      if (nf < 16) begin
         flen[nf] = mbits / 8;
         for (int j = 0; j < 8; j++) flog[nf][j] = fb[j];
      end
      nf++;
      case (fb[0])
         8'h02, 8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60: busy_left = BUSY_POLLS;
         8'h05: if (busy_left > 0) busy_left--;
         default: ;
      endcase
   end

   initial forever begin
      @(posedge clk);
      #1;
      if (done) done_cnt++;
      if (err) err_cnt++;
      if (rd_valid) begin
         if (rd_cnt < 16) rdb[rd_cnt] = rd_data;
         rd_cnt++;
      end
   end

   initial forever begin
      @(negedge clk);
      if (wr_ready) begin
         @(posedge clk);
         #1;
         wr_idx++;
         wr_data = pbuf[wr_idx[7:0]];
      end
   end

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R13 watchdog: done actual=0 expected=1");
      finish_sim();
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] k, input logic [23:0] a,
                        input logic [LEN_W-1:0] n, input logic [1:0] w);
      nf = 0; rd_cnt = 0; done_cnt = 0; err_cnt = 0; gap_min = 1.0e9;
      wr_idx = 0; wr_data = pbuf[0];
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_len = n; req_wrap = w;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R13 ready low after accept", {31'b0, req_ready}, 32'd0);
      while (done_cnt == 0 && err_cnt == 0) @(negedge clk);
      chk("R13 ready back at end", {31'b0, req_ready}, 32'd1);
      repeat (4) @(negedge clk);
      chk("R13 single end pulse", done_cnt + err_cnt, 32'd1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 cs_n after reset", {31'b0, spi_cs_n}, 32'd1);
      chk("R1 sclk after reset", {31'b0, spi_sclk}, 32'd0);
      chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
   endtask

   task automatic t_read();
      int bad;
      issue(4'd0, 24'h012345, 9'd4, 2'd0);
      chk("R3 frame count", nf, 1);
      chk("R2 R3 header", {flog[0][0], flog[0][1], flog[0][2], flog[0][3]}, 32'h03012345);
      chk("R3 frame length", flen[0], 8);
      chk("R3 byte count", rd_cnt, 4);
      bad = 0;
      for (int i = 0; i < 4; i++) if (rdb[i] !== memb(24'h012345 + 24'(i))) bad++;
      chk("R3 read data", bad, 0);
      chk("R3 done", done_cnt, 1);
   endtask

   task automatic t_fast();
      int bad;
      issue(4'd1, 24'h00ABF0, 9'd3, 2'd0);
      chk("R4 opcode and address", {flog[0][0], flog[0][1], flog[0][2], flog[0][3]}, 32'h0B00ABF0);
      chk("R4 dummy byte", flog[0][4], 8'h00);
      chk("R4 frame length", flen[0], 8);
      bad = 0;
      for (int i = 0; i < 3; i++) if (rdb[i] !== memb(24'h00ABF0 + 24'(i))) bad++;
      chk("R4 read data", bad, 0);
   endtask

   task automatic t_prog(input logic [23:0] a, input int n);
      int bad;
      for (int i = 0; i < 256; i++) pbuf[i] = 8'(i * 7 + 8'h11);
      issue(4'd2, a, LEN_W'(n), 2'd0);
      chk("R5 wren frame", {flog[0][0], 24'(flen[0])}, {8'h06, 24'd1});
      chk("R6 program header", {flog[1][0], flog[1][1], flog[1][2], flog[1][3]}, {8'h02, a});
      chk("R6 program length", flen[1], 4 + n);
      bad = 0;
      for (int i = 0; i < n; i++) if (dcap[i] !== pbuf[i]) bad++;
      chk("R6 program data", bad, 0);
      chk("R8 frames incl polls", nf, 5);
      chk("R8 poll opcode", {flog[2][0], flog[3][0], flog[4][0]}, 24'h050505);
      chk("R8 done after idle", done_cnt, 1);
      chk("R8 no poll data out", rd_cnt, 0);
      chk("R5 cs gap", {31'b0, gap_min >= (CS_HIGH - 0.01)}, 32'd1);
   endtask

   task automatic t_reject();
      issue(4'd2, 24'h0000F1, 9'd16, 2'd0);
      chk("R6 over page err", err_cnt, 1);
      chk("R6 over page no frame", nf, 0);
      chk("R6 over page no done", done_cnt, 0);
      issue(4'd2, 24'h000010, 9'd0, 2'd0);
      chk("R6 zero len program err", err_cnt, 1);
      issue(4'd0, 24'h000010, 9'd0, 2'd0);
      chk("R6 zero len read err", err_cnt, 1);
      chk("R6 zero len read no frame", nf, 0);
   endtask

   task automatic t_erase(input logic [3:0] k, input logic [7:0] op, input int ln);
      issue(k, 24'h3A5000, 9'd0, 2'd0);
      chk("R5 erase wren", flog[0][0], 8'h06);
      chk("R7 erase opcode", flog[1][0], op);
      chk("R7 erase length", flen[1], ln);
      if (ln == 4)
         chk("R7 erase address", {flog[1][1], flog[1][2], flog[1][3]}, 24'h3A5000);
      chk("R8 erase polls", nf, 5);
   endtask

   task automatic t_status_id();
      busy_left = 1;
      issue(4'd7, 24'h0, 9'd0, 2'd0);
      chk("R9 status frame", {flog[0][0], 24'(flen[0])}, {8'h05, 24'd2});
      chk("R9 status byte", {rdb[0], 24'(rd_cnt)}, {8'h01, 24'd1});
      issue(4'd8, 24'h0, 9'd0, 2'd0);
      chk("R9 id frame", {flog[0][0], 24'(flen[0])}, {8'h9F, 24'd4});
      chk("R9 id bytes", {rdb[0], rdb[1], rdb[2], 8'(rd_cnt)}, 32'hA1B2C303);
   endtask

   task automatic t_single(input logic [3:0] k, input logic [7:0] op);
      issue(k, 24'hFFFFFF, 9'd0, 2'd0);
      chk("R10 single frame", {flog[0][0], 8'(flen[0]), 16'(nf)}, {op, 8'd1, 16'd1});
   endtask

   task automatic t_reset_cmd();
      issue(4'd11, 24'h0, 9'd0, 2'd0);
      chk("R11 two frames", nf, 2);
      chk("R11 arm then go", {flog[0][0], flog[1][0]}, 16'h6699);
      chk("R11 one byte each", {8'(flen[0]), 8'(flen[1])}, 16'h0101);
   endtask

   task automatic t_wrap(input logic [1:0] w, input logic [7:0] wb);
      issue(4'd12, 24'h123456, 9'd0, w);
      chk("R12 wrap header", {flog[0][0], flog[0][1], flog[0][2], flog[0][3]}, 32'h77000000);
      chk("R12 wrap byte", flog[0][4], wb);
      chk("R12 wrap length", flen[0], 5);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_read();
      t_fast();
      t_prog(24'h1000F0, 16);
      t_prog(24'h200000, 256);
      t_reject();
      t_erase(4'd3, 8'h20, 4);
      t_erase(4'd4, 8'h52, 4);
      t_erase(4'd5, 8'hD8, 4);
      t_erase(4'd6, 8'hC7, 1);
      t_status_id();
      t_single(4'd9, 8'hB9);
      t_single(4'd10, 8'hAB);
      t_single(4'd13, 8'h04);
      t_reset_cmd();
      t_wrap(2'd2, 8'h40);
      t_wrap(2'd3, 8'h60);
      finish_sim();
   end

endmodule